// File: doc/BRIEF.md
# Multi-size partitioned transpose memory

This block sits between the row pass and the column pass of a two-dimensional transform. It holds the intermediate matrix, taking it in row by row and giving it back column by column. Both directions move 32 sixteen-bit samples per cycle at every supported edge length: 4, 8, 16 and 32. Storage is 32 single-port banks, each 32 words deep. A bank either writes or reads in a given cycle, never both.

An edge length N below 32 fills the bus with P = 32/N rows per write beat, and the same number of columns per read beat. The matrix is divided into PxP tiles. Each tile is stored in a group of P*P consecutive banks, all at one word address. The group is chosen by rotating the tile column by the tile row. On read, a lane-steering array undoes the rotation and turns each tile on its diagonal. At edge length 4, two whole matrices fit in one beat. These are transposed in the steering array alone and never touch the banks.

Top module: `tpm_transpose`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low.
- R2: `size_sel` codes 0, 1, 2, 3 select edge length N = 4, 8, 16, 32. Each beat carries P = 32/N rows (write) or columns (read). Sample lane L occupies `wr_data`/`rd_data` bits [16L+15:16L].
- R3: At N = 4, a write beat carries two matrices. Element (row r, column c) of matrix m is on input lane 16m+4r+c. One cycle later, `rd_valid` is high and output lane 16m+4c+r carries that element. `busy` stays low.
- R4: At N >= 8, write beat w places element (wP+i, c) on lane iN+c, for i < P. The matrix is complete after N*N/32 accepted beats: 2, 8 or 32.
- R5: Once a matrix is complete, read beat k returns element (r, kP+j) on lane jN+r. The matrix is drained after N*N/32 accepted read beats.
- R6: `rd_valid` is high exactly in the cycle after an accepted read beat or an N = 4 write beat. It is low in every other cycle.
- R7: `busy` rises with the first stored write beat and falls after the last read beat of that matrix. While `busy` is high, `size_sel` is ignored.
- R8: While a complete matrix waits to be read, `wr_en` is ignored, so reads still return the stored matrix. No cycle both stores and reads.
- R9: `rd_en` with no complete matrix stored is ignored, and `rd_valid` stays low.
- R10: Beats may be separated by idle cycles of any length. Once `busy` is low, a matrix of any size may follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_sel | input | 2 | Edge length code, sampled while not busy |
| wr_en | input | 1 | Write beat request |
| wr_data | input | 512 | 32 write samples, lane L at bits 16L+15:16L |
| rd_en | input | 1 | Read beat request |
| rd_data | output | 512 | 32 read samples, valid when `rd_valid` is high |
| rd_valid | output | 1 | `rd_data` holds a beat |
| busy | output | 1 | A matrix is partly written, complete, or partly read |

## Verification
The bench builds the block at its default 32 lanes of 16 bits. This is the only configuration in which all four edge lengths exist. At that size every beat of every matrix can be compared whole against a transpose computed in the bench. Each size gets matrices of distinct values, so a misrouted lane or a wrong rotation shows up in some beat. Idle gaps, size-select changes during a matrix, writes into a full matrix and reads from an empty one are each mixed into those sweeps.

// File: rtl/tpm_pkg.sv
`timescale 1ns/1ps
package tpm_pkg;

  // Size codes, smallest first; the code is added to a log2 offset.
  typedef enum logic [1:0] {
    SZ_E4  = 2'd0,
    SZ_E8  = 2'd1,
    SZ_E16 = 2'd2,
    SZ_E32 = 2'd3
  } tsize_e;

  // log2 of the matrix edge for a size code, ll = log2(lanes)
  function automatic int edge_log(input int ll, input logic [1:0] sz);
    return ll - 3 + int'(sz);
  endfunction

  // log2 of P, the rows per beat and the tile edge
  function automatic int part_log(input int ll, input logic [1:0] sz);
    return ll - edge_log(ll, sz);
  endfunction

  // log2 of the number of tiles per tile row (= bank groups = beats)
  function automatic int grp_log(input int ll, input logic [1:0] sz);
    int g;
    g = edge_log(ll, sz) - part_log(ll, sz);
    return (g < 0) ? 0 : g;
  endfunction

  function automatic int beat_count(input int ll, input logic [1:0] sz);
    return 1 << grp_log(ll, sz);
  endfunction

  // Write side: which input lane feeds bank 'bank' on beat 'beat'.
  function automatic int store_src_lane(input int ll, input logic [1:0] sz,
                                        input int bank, input int beat);
    int el, pl, gl, g, off, i, j, bc;
    el  = edge_log(ll, sz);
    pl  = part_log(ll, sz);
    gl  = grp_log(ll, sz);
    g   = bank >> (2 * pl);
    off = bank & ((1 << (2 * pl)) - 1);
    i   = off >> pl;
    j   = off & ((1 << pl) - 1);
    bc  = (g - beat) & ((1 << gl) - 1);
    return (i << el) | (bc << pl) | j;
  endfunction

  // Read side: which bank feeds output lane 'olane' on read beat 'beat'.
  function automatic int fetch_bank(input int ll, input logic [1:0] sz,
                                    input int olane, input int beat);
    int el, pl, gl, j, rem, br, i, g;
    el  = edge_log(ll, sz);
    pl  = part_log(ll, sz);
    gl  = grp_log(ll, sz);
    j   = olane >> el;
    rem = olane & ((1 << el) - 1);
    br  = rem >> pl;
    i   = rem & ((1 << pl) - 1);
    g   = (beat + br) & ((1 << gl) - 1);
    return (g << (2 * pl)) | (i << pl) | j;
  endfunction

  // Read side: word address of bank 'bank' on read beat 'beat'.
  function automatic int fetch_word(input int ll, input logic [1:0] sz,
                                    input int bank, input int beat);
    int pl, gl, g;
    pl = part_log(ll, sz);
    gl = grp_log(ll, sz);
    g  = bank >> (2 * pl);
    return (g - beat) & ((1 << gl) - 1);
  endfunction

  // Edge-4 path: source lane of output lane 'olane' (two 4x4 per 32 lanes).
  function automatic int direct_src_lane(input int olane);
    return (olane & ~15) | ((olane & 3) << 2) | ((olane >> 2) & 3);
  endfunction

endpackage

// File: rtl/tpm_bank.sv
`timescale 1ns/1ps
module tpm_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single port: a write cycle performs no read
  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
    else if (re)
      rdata <= mem[addr];
  end
endmodule

// File: rtl/tpm_xbar.sv
`timescale 1ns/1ps
module tpm_xbar #(
  parameter int LANES = 32,
  parameter int DW    = 16,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] din,
  input  logic [LANES*LW-1:0] sel,
  output logic [LANES*DW-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] s;
    assign s = sel[l*LW +: LW];
    assign dout[l*DW +: DW] = din[s*DW +: DW];
  end
endmodule

// File: rtl/tpm_agen.sv
`timescale 1ns/1ps
module tpm_agen
  import tpm_pkg::*;
#(
  parameter int LANES = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [1:0]          sz_now,
  input  logic [LW-1:0]       beat_now,
  input  logic                is_store,
  input  logic [1:0]          sz_out,
  input  logic [LW-1:0]       beat_out,
  output logic [LANES*LW-1:0] bank_addr,
  output logic [LANES*LW-1:0] store_sel,
  output logic [LANES*LW-1:0] out_sel
);
  // per bank: write lane select and word address
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LW-1:0] rd_word;
    assign rd_word = LW'(fetch_word(LW, sz_now, b, int'(beat_now)));
    assign bank_addr[b*LW +: LW] = is_store ? beat_now : rd_word;
    assign store_sel[b*LW +: LW] = LW'(store_src_lane(LW, sz_now, b, int'(beat_now)));
  end

  // per output lane: source select, edge-4 beats bypass the banks
  for (genvar o = 0; o < LANES; o++) begin : g_out
    assign out_sel[o*LW +: LW] = (sz_out == SZ_E4)
                               ? LW'(direct_src_lane(o))
                               : LW'(fetch_bank(LW, sz_out, o, int'(beat_out)));
  end
endmodule

// File: rtl/tpm_transpose.sv
`timescale 1ns/1ps
module tpm_transpose
  import tpm_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 16,
  localparam int LW   = $clog2(LANES),
  localparam int BW   = LANES * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    size_sel,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_en,
  output logic [BW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy
);
  // matrix state
  logic          full_q;
  logic [LW-1:0] cnt_q;
  logic [1:0]    cur_sz_q;

  // named events for the checker
  logic [1:0]    sz_eff;
  logic          last_beat;
  logic          store_fire;
  logic          direct_fire;
  logic          rd_fire;

  // output side registers
  logic          valid_q;
  logic          use_direct_q;
  logic [1:0]    out_sz_q;
  logic [LW-1:0] out_beat_q;
  logic [BW-1:0] direct_q;

  logic [BW-1:0]       store_data;
  logic [BW-1:0]       bank_q;
  logic [BW-1:0]       out_src;
  logic [LANES*LW-1:0] bank_addr;
  logic [LANES*LW-1:0] store_sel;
  logic [LANES*LW-1:0] out_sel;

  assign busy        = full_q | (cnt_q != '0);
  assign sz_eff      = busy ? cur_sz_q : size_sel;
  assign last_beat   = (cnt_q == LW'(beat_count(LW, sz_eff) - 1));
  assign store_fire  = wr_en & ~full_q & (sz_eff != SZ_E4);
  assign direct_fire = wr_en & ~full_q & (sz_eff == SZ_E4);
  assign rd_fire     = rd_en & full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      cnt_q    <= '0;
      cur_sz_q <= SZ_E4;
    end else begin
      cur_sz_q <= sz_eff;
      if (store_fire || rd_fire) begin
        if (last_beat) begin
          full_q <= store_fire;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      use_direct_q <= 1'b0;
      out_sz_q     <= SZ_E4;
      out_beat_q   <= '0;
    end else begin
      valid_q <= rd_fire | direct_fire;
      if (rd_fire || direct_fire) begin
        use_direct_q <= direct_fire;
        out_sz_q     <= sz_eff;
        out_beat_q   <= cnt_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (direct_fire) direct_q <= wr_data;
  end

  tpm_agen #(.LANES(LANES)) u_agen (
    .sz_now   (sz_eff),
    .beat_now (cnt_q),
    .is_store (store_fire),
    .sz_out   (out_sz_q),
    .beat_out (out_beat_q),
    .bank_addr(bank_addr),
    .store_sel(store_sel),
    .out_sel  (out_sel)
  );

  // write steering: input lanes to banks
  tpm_xbar #(.LANES(LANES), .DW(DW)) u_wr_xbar (
    .din (wr_data),
    .sel (store_sel),
    .dout(store_data)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    tpm_bank #(.DW(DW), .DEPTH(LANES)) u_bank (
      .clk  (clk),
      .we   (store_fire),
      .re   (rd_fire),
      .addr (bank_addr[b*LW +: LW]),
      .wdata(store_data[b*DW +: DW]),
      .rdata(bank_q[b*DW +: DW])
    );
  end

  // read steering: banks (or held edge-4 beat) to output lanes
  assign out_src = use_direct_q ? direct_q : bank_q;

  tpm_xbar #(.LANES(LANES), .DW(DW)) u_rd_xbar (
    .din (out_src),
    .sel (out_sel),
    .dout(rd_data)
  );

  assign rd_valid = valid_q;
endmodule

// File: rtl/tpm_transpose_chk.sv
`timescale 1ns/1ps
module tpm_transpose_chk
  import tpm_pkg::*;
#(
  parameter int LANES = 32,
  localparam int LW   = $clog2(LANES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          busy,
  input logic          full_q,
  input logic [LW-1:0] cnt_q,
  input logic [1:0]    cur_sz_q,
  input logic          store_fire,
  input logic          direct_fire,
  input logic          rd_fire
);
  // R6: a beat accepted now is presented next cycle
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire || direct_fire) |=> rd_valid);

  // R6: no valid without an accepted beat
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_fire || direct_fire) |=> !rd_valid);

  // R7: size stays fixed across a matrix
  assert_size_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_sz_q));

  // R8: a full matrix accepts no writes
  assert_full_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !(store_fire || direct_fire));

  // R8: one bank access per cycle
  assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_fire, rd_fire}));

  // R9: no read without a complete matrix
  assert_empty_blocks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q |-> !rd_fire);

  // R3: edge-4 beats leave the block idle
  assert_direct_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    direct_fire |=> !busy);

  // R4/R5: beat counter stays inside the matrix
  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt_q) < beat_count(LW, cur_sz_q)));
endmodule

bind tpm_transpose tpm_transpose_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .busy       (busy),
  .full_q     (full_q),
  .cnt_q      (cnt_q),
  .cur_sz_q   (cur_sz_q),
  .store_fire (store_fire),
  .direct_fire(direct_fire),
  .rd_fire    (rd_fire)
);

// File: tb/tpm_transpose_test.sv
`timescale 1ns/1ps
module tpm_transpose_test;
  localparam int LANES = 32;
  localparam int DW    = 16;
  localparam int BW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    size_sel;
  logic          wr_en;
  logic [BW-1:0] wr_data;
  logic          rd_en;
  logic [BW-1:0] rd_data;
  logic          rd_valid;
  logic          busy;

  always #2.5 clk = ~clk;

  tpm_transpose uut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] mat [32][32];

  task automatic chk_bus(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++)
        mat[r][c] = DW'((seed * 7919) ^ (r * 37 + 1) * (c + 11) ^ (r << 10) ^ c);
  endtask

  // R4 layout: lane i*N+c holds element (w*P+i, c)
  function automatic logic [BW-1:0] wr_bus(input int n, input int w);
    logic [BW-1:0] b;
    int p;
    p = 32 / n;
    b = '0;
    for (int i = 0; i < p; i++)
      for (int c = 0; c < n; c++)
        b[(i*n + c)*DW +: DW] = mat[w*p + i][c];
    return b;
  endfunction

  // R5 layout: lane j*N+r holds element (r, k*P+j)
  function automatic logic [BW-1:0] rd_bus(input int n, input int k);
    logic [BW-1:0] b;
    int p;
    p = 32 / n;
    b = '0;
    for (int j = 0; j < p; j++)
      for (int r = 0; r < n; r++)
        b[(j*n + r)*DW +: DW] = mat[r][k*p + j];
    return b;
  endfunction

  task automatic write_matrix(input int sz, input bit gap, input bit wobble);
    int n, g;
    n = 4 << sz;
    g = n * n / 32;
    for (int w = 0; w < g; w++) begin
      @(negedge clk);
      if (w == 1) chk_bit("R7 busy after first stored beat", busy, 1'b1);
      size_sel = (wobble && w > 0) ? 2'(w) : 2'(sz);
      wr_en    = 1'b1;
      wr_data  = wr_bus(n, w);
      if (gap) begin
        @(negedge clk);
        wr_en = 1'b0;
        size_sel = wobble ? 2'd0 : 2'(sz);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk_bit("R4 busy once matrix complete", busy, 1'b1);
  endtask

  task automatic read_matrix(input int sz, input bit gap, input bit wobble);
    int n, g;
    n = 4 << sz;
    g = n * n / 32;
    for (int k = 0; k < g; k++) begin
      @(negedge clk);
      if (!gap && k > 0) begin
        chk_bit("R6 valid on read beat", rd_valid, 1'b1);
        chk_bus($sformatf("R5 size %0d beat %0d", n, k-1), rd_data, rd_bus(n, k-1));
      end
      rd_en = 1'b1;
      if (wobble) size_sel = 2'(k);
      if (gap) begin
        @(negedge clk);
        rd_en = 1'b0;
        chk_bit("R6 valid on read beat", rd_valid, 1'b1);
        chk_bus($sformatf("R5 size %0d beat %0d gap", n, k), rd_data, rd_bus(n, k));
        @(negedge clk);
        chk_bit("R6 valid low in idle cycle", rd_valid, 1'b0);
        if (k < g - 1) chk_bit("R7 busy during reads", busy, 1'b1);
      end
    end
    if (!gap) begin
      @(negedge clk);
      rd_en = 1'b0;
      chk_bit("R6 valid on last read beat", rd_valid, 1'b1);
      chk_bus($sformatf("R5 size %0d last beat", n), rd_data, rd_bus(n, g-1));
    end
    chk_bit("R7 busy low after last read", busy, 1'b0);
    size_sel = 2'(sz);
  endtask

  // R3: two 4x4 matrices per beat, lane 16m+4r+c in, 16m+4c+r out
  task automatic direct_beats(input int count, input int seed);
    logic [BW-1:0] exp_q;
    exp_q = '0;
    for (int t = 0; t <= count; t++) begin
      @(negedge clk);
      if (t > 0) begin
        chk_bit("R6 valid after edge-4 beat", rd_valid, 1'b1);
        chk_bus("R3 edge-4 transpose", rd_data, exp_q);
        chk_bit("R3 busy stays low", busy, 1'b0);
      end
      if (t < count) begin
        logic [BW-1:0] din;
        din = '0;
        exp_q = '0;
        for (int m = 0; m < 2; m++)
          for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
              logic [DW-1:0] v;
              v = DW'((seed + t) * 4099 + m * 311 + r * 53 + c * 7 + r * c);
              din[(16*m + 4*r + c)*DW +: DW] = v;
              exp_q[(16*m + 4*c + r)*DW +: DW] = v;
            end
        size_sel = 2'd0;
        wr_en    = 1'b1;
        wr_data  = din;
      end else begin
        wr_en = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    size_sel = 2'd0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    chk_bit("R1 busy after reset", busy, 1'b0);
    chk_bit("R1 rd_valid after reset", rd_valid, 1'b0);
    rst_n = 1'b1;

    // R9: read with nothing stored
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk_bit("R9 read on empty ignored", rd_valid, 1'b0);

    // R2/R3: edge length 4
    direct_beats(5, 1);
    @(negedge clk);
    chk_bit("R6 valid low after edge-4 beats", rd_valid, 1'b0);

    // R2/R4/R5: each stored size, consecutive beats
    for (int sz = 1; sz < 4; sz++) begin
      fill(sz);
      write_matrix(sz, 1'b0, 1'b0);
      // R8: write into a full matrix
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = {BW{1'b1}};
      @(negedge clk);
      wr_en = 1'b0;
      chk_bit("R8 write to full ignored", rd_valid, 1'b0);
      read_matrix(sz, 1'b0, 1'b0);
    end

    // R7/R10: gaps and size_sel changes mid-matrix
    fill(21);
    write_matrix(2, 1'b1, 1'b1);
    read_matrix(2, 1'b1, 1'b1);
    fill(33);
    write_matrix(3, 1'b0, 1'b1);
    read_matrix(3, 1'b0, 1'b1);
    fill(8);
    write_matrix(1, 1'b1, 1'b0);
    read_matrix(1, 1'b1, 1'b0);

    // R9: read after drain is ignored
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk_bit("R9 read after drain ignored", rd_valid, 1'b0);

    // R10: switch back to edge 4
    direct_beats(3, 50);
    fill(77);
    write_matrix(1, 1'b0, 1'b0);
    read_matrix(1, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule